// File: doc/BRIEF.md
# Dual-Width Gray Code Counter

This block keeps one binary count and presents it in two Gray-coded forms at once. The wide output is the reflected Gray code of the full `CNT_W`-bit count. The narrow output is a `CNT_W-1`-bit Gray code meant for addressing a memory of `2**(CNT_W-1)` words. A third output, the wrap flag, marks which half of the wide sequence the count is in.

The narrow code comes from the wide one and is not counted separately. When the wide MSB is 1, the wide code's second bit is inverted and the MSB is dropped. The bits below the second bit pass through unchanged. A single counter therefore serves both uses, for example a pointer that must cross a clock boundary and the memory address that goes with it. Joined to the wrap flag, the narrow code is not a true Gray code: the step into the upper half and the step back to zero each change two bits.

The count advances by one on each rising clock edge at which the enable is high. A synchronous active-low reset clears it. All outputs come straight from registers. `CNT_W` must be at least 3.

Top module: `gray_pair_counter`

## Requirements
- R1: When `rst_n` is low at a rising edge, all outputs read zero after that edge, even if `inc_en` is high.
- R2: A rising edge with `inc_en` low leaves all three outputs unchanged.
- R3: After k enabled edges since reset, `gray_o` equals m XOR (m >> 1), where m = k mod 2**CNT_W.
- R4: Every enabled edge changes exactly one bit of `gray_o`, including the step from the last count back to zero.
- R5: `addr_gray_o` equals the lower CNT_W-1 bits of `gray_o`, with bit CNT_W-2 XORed with `gray_o[CNT_W-1]`. This equals the reflected Gray code of k mod 2**(CNT_W-1).
- R6: Bits CNT_W-3 down to 0 of `addr_gray_o` are always equal to the same bits of `gray_o`.
- R7: Every enabled edge changes exactly one bit of `addr_gray_o`, and the sequence returns to zero after 2**(CNT_W-1) steps.
- R8: `wrap_o` equals `gray_o[CNT_W-1]`, which is bit CNT_W-1 of the count. It toggles exactly on the enabled edges after which `addr_gray_o` is zero.
- R9: Outputs change only at rising edges. Toggling `inc_en` between edges, and returning it low before the next edge, has no effect on the outputs.
- R10: For CNT_W = 4, the concatenation {`wrap_o`, `addr_gray_o`} steps from 0100 to 1000 at count 7 to 8, and from 1100 to 0000 at count 15 to 0. Each of these steps changes two bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| inc_en | input | 1 | Advance the count by one at this edge |
| gray_o | output | CNT_W | Reflected Gray code of the full count |
| addr_gray_o | output | CNT_W-1 | Folded Gray code for memory addressing |
| wrap_o | output | 1 | Upper-half flag; toggles once per narrow-sequence wrap |

## Verification
The bench builds three copies of the block, with widths 3, 4 and 6, and drives them in lockstep. The 6-bit copy runs through two full laps of its 64-state sequence, so every wrap of the wide code and of the narrow code is reached at each width, including the narrowest case, where the pass-through field is one bit wide. The 4-bit copy makes it possible to check the two double-bit transitions of the joined code against literal values.

// File: rtl/gray_pair_pkg.sv
// Package: gray_pair_pkg
// Shared helpers for the dual-width Gray counter.
// Assumes vectors no wider than 32 bits.
package gray_pair_pkg;

    // Reflected binary-to-Gray conversion on a 32-bit container.
    function automatic logic [31:0] bin_to_gray(input logic [31:0] bin);
        return bin ^ (bin >> 1);
    endfunction

endpackage

// File: rtl/gray_bin_count.sv
// Module: gray_bin_count
// Holds the binary count and supplies the value it takes at the next edge.
// Assumes a synchronous active-low reset; the count wraps modulo 2**W.
module gray_bin_count #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc_en,
    output logic [W-1:0] count_nxt
);
    logic [W-1:0] count_q;

    // Next count: current plus one when enabled, zero under reset.
    always_comb begin
        if (!rst_n) count_nxt = '0;
        else        count_nxt = count_q + W'(inc_en);
    end

    // State register for the binary count.
    always_ff @(posedge clk) begin
        count_q <= count_nxt;
    end
endmodule

// File: rtl/gray_code_reg.sv
// Module: gray_code_reg
// Encodes the next binary count as reflected Gray and registers it.
// Assumes the binary input already reflects reset, so the register
// and the count stay aligned.
module gray_code_reg
    import gray_pair_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic [W-1:0] bin_nxt,
    output logic [W-1:0] gray_nxt,
    output logic [W-1:0] gray_q
);
    logic [31:0] wide_gray;

    // Combinational encode of the next count.
    always_comb begin
        wide_gray = bin_to_gray(32'(bin_nxt));
        gray_nxt  = wide_gray[W-1:0];
    end

    // Output register for the wide Gray code.
    always_ff @(posedge clk) begin
        gray_q <= gray_nxt;
    end
endmodule

// File: rtl/gray_fold.sv
// Module: gray_fold
// Folds a W-bit reflected Gray code into a (W-1)-bit Gray code that
// counts the low half of the sequence.
// Assumes W >= 3, so a pass-through field of at least one bit exists.
module gray_fold #(
    parameter int W = 4
) (
    input  logic [W-1:0] gray_in,
    output logic [W-2:0] gray_fold_out
);
    localparam int PASS_W = W - 2;

    // Invert the second bit in the upper half; the lower bits pass through.
    always_comb begin
        gray_fold_out[W-2]        = gray_in[W-2] ^ gray_in[W-1];
        gray_fold_out[PASS_W-1:0] = gray_in[PASS_W-1:0];
    end
endmodule

// File: rtl/gray_pair_counter.sv
// Module: gray_pair_counter (top)
// One count register with two registered Gray views: the full CNT_W-bit
// code and a folded (CNT_W-1)-bit code for addressing. The wrap flag is
// the wide MSB.
// Assumes CNT_W >= 3 and a synchronous active-low reset.
module gray_pair_counter #(
    parameter int CNT_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               inc_en,
    output logic [CNT_W-1:0]   gray_o,
    output logic [CNT_W-2:0]   addr_gray_o,
    output logic               wrap_o
);
    localparam int ADDR_W = CNT_W - 1;

    logic [CNT_W-1:0]  bin_nxt;
    logic [CNT_W-1:0]  gray_nxt;
    logic [ADDR_W-1:0] addr_nxt;
    logic [ADDR_W-1:0] addr_q;

    gray_bin_count #(.W(CNT_W)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .inc_en    (inc_en),
        .count_nxt (bin_nxt)
    );

    gray_code_reg #(.W(CNT_W)) u_gray (
        .clk      (clk),
        .bin_nxt  (bin_nxt),
        .gray_nxt (gray_nxt),
        .gray_q   (gray_o)
    );

    gray_fold #(.W(CNT_W)) u_fold (
        .gray_in       (gray_nxt),
        .gray_fold_out (addr_nxt)
    );

    // Output register for the folded address code.
    always_ff @(posedge clk) begin
        addr_q <= addr_nxt;
    end

    assign addr_gray_o = addr_q;
    assign wrap_o      = gray_o[CNT_W-1];
endmodule

// File: rtl/gray_pair_counter_chk.sv
// Module: gray_pair_counter_chk
// Checks gray_pair_counter at its ports over time. Bound to every
// instance of the top module.
module gray_pair_counter_chk #(
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             inc_en,
    input logic [CNT_W-1:0] gray_o,
    input logic [CNT_W-2:0] addr_gray_o,
    input logic             wrap_o
);
    // R1: the first edge out of reset sees cleared outputs.
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (gray_o == '0 && addr_gray_o == '0 && !wrap_o));

    // R2: an idle edge holds every output.
    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !inc_en |=> ($stable(gray_o) && $stable(addr_gray_o) && $stable(wrap_o)));

    // R4: one wide bit flips per enabled step.
    assert_wide_one_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        inc_en |=> ($countones(gray_o ^ $past(gray_o)) == 1));

    // R7: one folded bit flips per enabled step.
    assert_addr_one_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        inc_en |=> ($countones(addr_gray_o ^ $past(addr_gray_o)) == 1));

    // R8: the wrap flag toggles exactly when the folded code returns to zero.
    assert_wrap_toggle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        inc_en |=> ((wrap_o != $past(wrap_o)) == (addr_gray_o == '0)));
endmodule

bind gray_pair_counter gray_pair_counter_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .inc_en      (inc_en),
    .gray_o      (gray_o),
    .addr_gray_o (addr_gray_o),
    .wrap_o      (wrap_o)
);

// File: tb/test_gray_pair_counter.sv
// Directed bench: three widths run in lockstep against a count model.
module test_gray_pair_counter;
    localparam int CLK_PERIOD = 10;
    localparam int NW = 3;
    localparam int WID [NW] = '{3, 4, 6};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic inc_en = 1'b0;

    logic [2:0] g3; logic [1:0] a3; logic w3;
    logic [3:0] g4; logic [2:0] a4; logic w4;
    logic [5:0] g6; logic [4:0] a6; logic w6;

    logic [7:0] g_s [NW];
    logic [7:0] a_s [NW];
    logic       w_s [NW];
    int         cnt [NW];
    int         checks = 0;
    int         fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gray_pair_counter #(.CNT_W(3)) i_gray_pair_counter_w3 (
        .clk(clk), .rst_n(rst_n), .inc_en(inc_en),
        .gray_o(g3), .addr_gray_o(a3), .wrap_o(w3));
    gray_pair_counter #(.CNT_W(4)) i_gray_pair_counter (
        .clk(clk), .rst_n(rst_n), .inc_en(inc_en),
        .gray_o(g4), .addr_gray_o(a4), .wrap_o(w4));
    gray_pair_counter #(.CNT_W(6)) i_gray_pair_counter_w6 (
        .clk(clk), .rst_n(rst_n), .inc_en(inc_en),
        .gray_o(g6), .addr_gray_o(a6), .wrap_o(w6));

    assign g_s[0] = 8'(g3); assign a_s[0] = 8'(a3); assign w_s[0] = w3;
    assign g_s[1] = 8'(g4); assign a_s[1] = 8'(a4); assign w_s[1] = w4;
    assign g_s[2] = 8'(g6); assign a_s[2] = 8'(a6); assign w_s[2] = w6;

    function automatic logic [7:0] exp_gray(input int k, input int w);
        int m;
        m = k % (1 << w);
        return 8'(m ^ (m >> 1));
    endfunction

    function automatic int ones(input logic [7:0] v);
        int n = 0;
        for (int b = 0; b < 8; b++) n += int'(v[b]);
        return n;
    endfunction

    task automatic expect8(input string req, input int w,
                           input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s width=%0d actual=%0h expected=%0h", req, w, act, exp);
        end
    endtask

    // One clock with the given enable; returns at a falling edge.
    task automatic step(input bit en);
        inc_en = en;
        @(posedge clk);
        @(negedge clk);
        inc_en = 1'b0;
        if (en) for (int i = 0; i < NW; i++) cnt[i]++;
    endtask

    task automatic apply_reset();
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NW; i++) cnt[i] = 0;
    endtask

    // Compare every instance against the model (R3, R5, R6, R8).
    task automatic check_state();
        for (int i = 0; i < NW; i++) begin
            int w = WID[i];
            logic [7:0] eg = exp_gray(cnt[i], w);
            logic [7:0] lowmask = 8'((1 << (w - 2)) - 1);
            logic [7:0] fold;
            expect8("R3 gray value", w, g_s[i], eg);
            fold = (eg & 8'((1 << (w - 1)) - 1)) ^ (8'(eg[w-1]) << (w - 2));
            expect8("R5 folded value", w, a_s[i], exp_gray(cnt[i], w - 1));
            expect8("R5 fold of gray", w, a_s[i], fold);
            expect8("R6 shared low bits", w, a_s[i] & lowmask, g_s[i] & lowmask);
            expect8("R8 wrap flag", w, 8'(w_s[i]), 8'((cnt[i] >> (w - 1)) & 1));
        end
    endtask

    task automatic test_reset_state();
        apply_reset();
        for (int i = 0; i < NW; i++) begin
            expect8("R1 gray after reset", WID[i], g_s[i], 8'h00);
            expect8("R1 addr after reset", WID[i], a_s[i], 8'h00);
            expect8("R1 wrap after reset", WID[i], 8'(w_s[i]), 8'h00);
        end
    endtask

    task automatic test_sweep();
        logic [7:0] pg [NW];
        logic [7:0] pa [NW];
        for (int s = 0; s < 128; s++) begin
            for (int i = 0; i < NW; i++) begin pg[i] = g_s[i]; pa[i] = a_s[i]; end
            step(1'b1);
            check_state();
            for (int i = 0; i < NW; i++) begin
                expect8("R4 wide bit flips", WID[i], 8'(ones(g_s[i] ^ pg[i])), 8'd1);
                expect8("R7 folded bit flips", WID[i], 8'(ones(a_s[i] ^ pa[i])), 8'd1);
                if (cnt[i] % (1 << (WID[i] - 1)) == 0)
                    expect8("R7 folded wrap to zero", WID[i], a_s[i], 8'h00);
            end
        end
    endtask

    task automatic test_hold();
        logic [7:0] sg [NW];
        for (int s = 0; s < 5; s++) step(1'b1);
        for (int i = 0; i < NW; i++) sg[i] = g_s[i];
        for (int s = 0; s < 6; s++) begin
            step(1'b0);
            for (int i = 0; i < NW; i++)
                expect8("R2 idle hold", WID[i], g_s[i], sg[i]);
        end
        check_state();
    endtask

    task automatic test_reset_priority();
        for (int s = 0; s < 9; s++) step(1'b1);
        inc_en = 1'b1;
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        inc_en = 1'b0;
        for (int i = 0; i < NW; i++) begin
            cnt[i] = 0;
            expect8("R1 reset beats enable", WID[i], g_s[i], 8'h00);
        end
        check_state();
    endtask

    task automatic test_between_edges();
        logic [7:0] sg [NW];
        step(1'b1); step(1'b1);
        for (int i = 0; i < NW; i++) sg[i] = g_s[i];
        @(posedge clk);
        #1 inc_en = 1'b1;
        #2;
        for (int i = 0; i < NW; i++)
            expect8("R9 mid-cycle enable", WID[i], g_s[i], sg[i]);
        #1 inc_en = 1'b0;
        @(posedge clk);
        @(negedge clk);
        for (int i = 0; i < NW; i++)
            expect8("R9 no edge with enable", WID[i], g_s[i], sg[i]);
        check_state();
    endtask

    task automatic test_joined_msb();
        logic [3:0] prev;
        apply_reset();
        for (int s = 0; s < 7; s++) step(1'b1);
        expect8("R10 joined at 7", 4, {4'h0, w4, a4}, 8'b0100);
        prev = {w4, a4};
        step(1'b1);
        expect8("R10 joined at 8", 4, {4'h0, w4, a4}, 8'b1000);
        expect8("R10 two bits 7->8", 4, 8'(ones(8'({w4, a4} ^ prev))), 8'd2);
        for (int s = 0; s < 7; s++) step(1'b1);
        expect8("R10 joined at 15", 4, {4'h0, w4, a4}, 8'b1100);
        prev = {w4, a4};
        step(1'b1);
        expect8("R10 joined at 0", 4, {4'h0, w4, a4}, 8'b0000);
        expect8("R10 two bits 15->0", 4, 8'(ones(8'({w4, a4} ^ prev))), 8'd2);
    endtask

    initial begin
        for (int i = 0; i < NW; i++) cnt[i] = 0;
        @(negedge clk);
        @(negedge clk);
        test_reset_state();
        test_sweep();
        test_hold();
        test_reset_priority();
        test_between_edges();
        test_joined_msb();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule